// File: doc/BRIEF.md
# Transaction Abort Responder for an IO Bridge Subordinate Path

This block sits on an AXI-style subordinate path between IO requesters and memory. Each write address and read address request arrives with two check results from the attribute and protection checkers, plus a flag that marks it as issued by the address translation unit for its own table walks. A global failed-state input from the translation unit applies to every request.

Requests that are allowed go to the memory side unchanged, and the memory responses come back unchanged. A write that must be aborted never reaches memory. Its data beats are absorbed and the requester gets an error write response. A read that must be aborted is answered locally with fill data and an error status on every beat. When the aborted request came from the translation unit, no response goes to the requester side. A one-cycle fault indication carrying the request ID goes back to the translation unit instead.

The block handles one transaction at a time. Responses therefore leave in the order the requests were accepted.

Top module: `abort_responder`

## Requirements
- R1: A request whose attribute and protection checks both pass, and that is not blocked by the failed state, is forwarded to the memory side with the same ID, address and length. Its write beats (data, strobe, last) and the memory's write/read responses are passed back unchanged.
- R2: A request with an attribute fault or a protection fault produces no address, write data or read request on the memory side.
- R3: For an aborted write from a device, every write beat up to and including the one with last set is accepted and discarded. Exactly one write response then follows, with response code 2'b10 (error) and the request's ID, held until taken.
- R4: For an aborted read from a device, exactly len+1 read beats are returned. Each beat carries response code 2'b10 and the request's ID, and last is set only on the final beat.
- R5: The data of every locally generated read beat is the fill word, selected by parameter FILL_ONES. With the default of 1 the word is all ones; with 0 it is all zeros.
- R6: An aborted request that is marked as issued by the translation unit produces no write or read response. Instead, fault_valid is high for exactly one cycle, with fault_id equal to the request ID and fault_write equal to 1 for a write and 0 for a read. For writes, this happens after the write beats are absorbed.
- R7: While failed_state is high, every request not marked as issued by the translation unit is aborted. A translation-unit request with passing checks is still forwarded.
- R8: Only one transaction is in flight at a time. The address channels are never both ready, and write and read responses are never presented together, so responses follow request acceptance order.
- R9: After reset, no valid is asserted on any response channel, on the memory-side request channels, or on the fault output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| failed_state | input | 1 | Translation unit is in a failed state |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awid | input | ID_W | Write ID |
| s_awaddr | input | ADDR_W | Write address |
| s_awlen | input | LEN_W | Write burst length minus one |
| s_aw_attr_fault | input | 1 | Attribute check failed for this write |
| s_aw_prot_fault | input | 1 | Protection check failed for this write |
| s_aw_internal | input | 1 | Write issued by the translation unit |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write strobes |
| s_wlast | input | 1 | Final write beat |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_arid | input | ID_W | Read ID |
| s_araddr | input | ADDR_W | Read address |
| s_arlen | input | LEN_W | Read burst length minus one |
| s_ar_attr_fault | input | 1 | Attribute check failed for this read |
| s_ar_prot_fault | input | 1 | Protection check failed for this read |
| s_ar_internal | input | 1 | Read issued by the translation unit |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rid | output | ID_W | Read ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Final read beat |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_awid | output | ID_W | Memory write ID |
| m_awaddr | output | ADDR_W | Memory write address |
| m_awlen | output | LEN_W | Memory write length |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_wdata | output | DATA_W | Memory write data |
| m_wstrb | output | DATA_W/8 | Memory write strobes |
| m_wlast | output | 1 | Memory final write beat |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |
| m_bid | input | ID_W | Memory write response ID |
| m_bresp | input | 2 | Memory write response code |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_arid | output | ID_W | Memory read ID |
| m_araddr | output | ADDR_W | Memory read address |
| m_arlen | output | LEN_W | Memory read length |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_rid | input | ID_W | Memory read ID |
| m_rdata | input | DATA_W | Memory read data |
| m_rresp | input | 2 | Memory read response code |
| m_rlast | input | 1 | Memory final read beat |
| fault_valid | output | 1 | Access fault to the translation unit |
| fault_id | output | ID_W | ID of the faulting request |
| fault_write | output | 1 | Faulting request was a write |

## Verification
The bench targets these corner cases:
- Single-beat aborted reads. A counter off by one would return two beats or drop last.
- Aborted writes with long bursts and a stalling data source. A design that answered early would respond before last, or leave beats stranded.
- Translation-unit requests during the failed state. A design that ignored the internal flag would abort walks that should proceed, or answer a device where only the fault pulse is allowed.
- Simultaneous write and read requests. A design that took both at once would overlap responses or lose one of them.

// File: rtl/abort_pkg.sv
package abort_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_AW_FWD,
    ST_W_FWD,
    ST_B_FWD,
    ST_W_DROP,
    ST_B_ERR,
    ST_AR_FWD,
    ST_R_FWD,
    ST_R_ERR,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/abort_decide.sv
module abort_decide (
  input  logic attr_fault,
  input  logic prot_fault,
  input  logic internal,
  input  logic failed,
  output logic abort,
  output logic to_initiator
);
  // Failed state blocks device traffic only; table walks still need checking.
  always_comb begin
    abort        = attr_fault | prot_fault | (failed & ~internal);
    to_initiator = abort & internal;
  end
endmodule

// File: rtl/abort_beat_ctr.sv
module abort_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             step,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      len_q <= len_in;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == len_q);
endmodule

// File: rtl/abort_responder.sv
module abort_responder
  import abort_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 8,
  parameter bit FILL_ONES = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                failed_state,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [LEN_W-1:0]    s_awlen,
  input  logic                s_aw_attr_fault,
  input  logic                s_aw_prot_fault,
  input  logic                s_aw_internal,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ID_W-1:0]     s_arid,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [LEN_W-1:0]    s_arlen,
  input  logic                s_ar_attr_fault,
  input  logic                s_ar_prot_fault,
  input  logic                s_ar_internal,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_W-1:0]     s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ID_W-1:0]     m_arid,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [LEN_W-1:0]    m_arlen,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [ID_W-1:0]     m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  output logic                fault_valid,
  output logic [ID_W-1:0]     fault_id,
  output logic                fault_write
);
  localparam logic [DATA_W-1:0] FILL_WORD = {DATA_W{FILL_ONES}};

  seq_state_e        st_q, st_d;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              route_q;
  logic              wr_q;
  logic              prio_wr_q;

  logic idle, pick_w, aw_fire, ar_fire;
  logic abort_w, route_w, abort_r, route_r;
  logic err_last, err_step;

  abort_decide u_dec_w (
    .attr_fault  (s_aw_attr_fault),
    .prot_fault  (s_aw_prot_fault),
    .internal    (s_aw_internal),
    .failed      (failed_state),
    .abort       (abort_w),
    .to_initiator(route_w)
  );

  abort_decide u_dec_r (
    .attr_fault  (s_ar_attr_fault),
    .prot_fault  (s_ar_prot_fault),
    .internal    (s_ar_internal),
    .failed      (failed_state),
    .abort       (abort_r),
    .to_initiator(route_r)
  );

  abort_beat_ctr #(.LEN_W(LEN_W)) u_beats (
    .clk   (clk),
    .rst   (rst),
    .load  (ar_fire),
    .len_in(s_arlen),
    .step  (err_step),
    .last  (err_last)
  );

  // Address acceptance: one transaction at a time, alternating priority.
  always_comb begin
    idle      = (st_q == ST_IDLE);
    pick_w    = s_awvalid & (prio_wr_q | ~s_arvalid);
    s_awready = idle & pick_w;
    s_arready = idle & ~pick_w;
    aw_fire   = s_awvalid & s_awready;
    ar_fire   = s_arvalid & s_arready;
    err_step  = (st_q == ST_R_ERR) & s_rready;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (aw_fire)      st_d = abort_w ? ST_W_DROP : ST_AW_FWD;
        else if (ar_fire) st_d = abort_r ? (route_r ? ST_FAULT : ST_R_ERR) : ST_AR_FWD;
      end
      ST_AW_FWD: if (m_awready) st_d = ST_W_FWD;
      ST_W_FWD:  if (s_wvalid && m_wready && s_wlast) st_d = ST_B_FWD;
      ST_B_FWD:  if (m_bvalid && s_bready) st_d = ST_IDLE;
      ST_W_DROP: if (s_wvalid && s_wlast) st_d = route_q ? ST_FAULT : ST_B_ERR;
      ST_B_ERR:  if (s_bready) st_d = ST_IDLE;
      ST_AR_FWD: if (m_arready) st_d = ST_R_FWD;
      ST_R_FWD:  if (m_rvalid && s_rready && m_rlast) st_d = ST_IDLE;
      ST_R_ERR:  if (s_rready && err_last) st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      id_q      <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      route_q   <= 1'b0;
      wr_q      <= 1'b0;
      prio_wr_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (aw_fire) begin
        id_q      <= s_awid;
        addr_q    <= s_awaddr;
        len_q     <= s_awlen;
        route_q   <= route_w;
        wr_q      <= 1'b1;
        prio_wr_q <= 1'b0;
      end else if (ar_fire) begin
        id_q      <= s_arid;
        addr_q    <= s_araddr;
        len_q     <= s_arlen;
        route_q   <= route_r;
        wr_q      <= 1'b0;
        prio_wr_q <= 1'b1;
      end
    end
  end

  // Memory-side request channels driven from captured request fields.
  always_comb begin
    m_awvalid = (st_q == ST_AW_FWD);
    m_awid    = id_q;
    m_awaddr  = addr_q;
    m_awlen   = len_q;
    m_arvalid = (st_q == ST_AR_FWD);
    m_arid    = id_q;
    m_araddr  = addr_q;
    m_arlen   = len_q;
  end

  // Write data and response path: pass through or absorb and answer locally.
  always_comb begin
    m_wvalid = (st_q == ST_W_FWD) & s_wvalid;
    m_wdata  = s_wdata;
    m_wstrb  = s_wstrb;
    m_wlast  = s_wlast;
    s_wready = ((st_q == ST_W_FWD) & m_wready) | (st_q == ST_W_DROP);
    m_bready = (st_q == ST_B_FWD) & s_bready;
    s_bvalid = ((st_q == ST_B_FWD) & m_bvalid) | (st_q == ST_B_ERR);
    s_bid    = (st_q == ST_B_FWD) ? m_bid : id_q;
    s_bresp  = (st_q == ST_B_FWD) ? m_bresp : RESP_SLVERR;
  end

  // Read response path: pass through or generate fill beats.
  always_comb begin
    m_rready = (st_q == ST_R_FWD) & s_rready;
    s_rvalid = ((st_q == ST_R_FWD) & m_rvalid) | (st_q == ST_R_ERR);
    s_rid    = (st_q == ST_R_FWD) ? m_rid   : id_q;
    s_rdata  = (st_q == ST_R_FWD) ? m_rdata : FILL_WORD;
    s_rresp  = (st_q == ST_R_FWD) ? m_rresp : RESP_SLVERR;
    s_rlast  = (st_q == ST_R_FWD) ? m_rlast : err_last;
  end

  always_comb begin
    fault_valid = (st_q == ST_FAULT);
    fault_id    = id_q;
    fault_write = wr_q;
  end

  // R2
  no_fwd_aw_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (aw_fire && abort_w) |=> !m_awvalid && !m_wvalid);
  // R2
  no_fwd_ar_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (ar_fire && abort_r) |=> !m_arvalid);
  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid) && $stable(s_bresp)));
  // R4
  err_read_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_R_ERR && s_rvalid && s_rready && s_rlast) |=> !s_rvalid);
  // R6
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);
  // R6
  fault_silent_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!s_bvalid && !s_rvalid));
  // R8
  single_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !(s_awready && s_arready));
  // R8
  no_resp_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(s_bvalid && s_rvalid));
endmodule

// File: tb/abort_responder_tb.sv
`timescale 1ns/100ps
module abort_responder_tb;
  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 64, LEN_W = 8, SW = DATA_W/8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic failed_state = 1'b0;
  logic s_awvalid = 0, s_awready; logic [ID_W-1:0] s_awid = 0; logic [ADDR_W-1:0] s_awaddr = 0;
  logic [LEN_W-1:0] s_awlen = 0; logic s_aw_attr_fault = 0, s_aw_prot_fault = 0, s_aw_internal = 0;
  logic s_wvalid = 0, s_wready; logic [DATA_W-1:0] s_wdata = 0; logic [SW-1:0] s_wstrb = '1; logic s_wlast = 0;
  logic s_bvalid, s_bready = 0; logic [ID_W-1:0] s_bid; logic [1:0] s_bresp;
  logic s_arvalid = 0, s_arready; logic [ID_W-1:0] s_arid = 0; logic [ADDR_W-1:0] s_araddr = 0;
  logic [LEN_W-1:0] s_arlen = 0; logic s_ar_attr_fault = 0, s_ar_prot_fault = 0, s_ar_internal = 0;
  logic s_rvalid, s_rready = 0; logic [ID_W-1:0] s_rid; logic [DATA_W-1:0] s_rdata; logic [1:0] s_rresp; logic s_rlast;
  logic m_awvalid, m_awready = 1; logic [ID_W-1:0] m_awid; logic [ADDR_W-1:0] m_awaddr; logic [LEN_W-1:0] m_awlen;
  logic m_wvalid, m_wready = 1; logic [DATA_W-1:0] m_wdata; logic [SW-1:0] m_wstrb; logic m_wlast;
  logic m_bvalid = 0, m_bready; logic [ID_W-1:0] m_bid = 0; logic [1:0] m_bresp = 0;
  logic m_arvalid, m_arready = 1; logic [ID_W-1:0] m_arid; logic [ADDR_W-1:0] m_araddr; logic [LEN_W-1:0] m_arlen;
  logic m_rvalid = 0, m_rready; logic [ID_W-1:0] m_rid = 0; logic [DATA_W-1:0] m_rdata = 0; logic [1:0] m_rresp = 0; logic m_rlast = 0;
  logic fault_valid; logic [ID_W-1:0] fault_id; logic fault_write;

  abort_responder u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_abort(bit failed, bit attr, bit prot, bit intl);
    return attr | prot | (failed & ~intl);
  endfunction

  function automatic logic [DATA_W-1:0] mem_word(logic [ADDR_W-1:0] a, int beat);
    return {a, 32'(beat) ^ 32'h5A00_0000};
  endfunction

  // Memory model: evaluates between clock edges, after the requester-side drivers.
  int mem_aw_cnt = 0, mem_w_cnt = 0, mem_ar_cnt = 0;
  logic [DATA_W-1:0] mem_wsum = 0;
  logic [ADDR_W-1:0] mem_awaddr = 0, r_addr = 0;
  logic [LEN_W-1:0] mem_awlen = 0;
  logic [ID_W-1:0] b_id = 0;
  bit pend_b = 0, pend_r = 0;
  int r_beat = 0, r_len = 0;
  always begin
    @(negedge clk); #1;
    if (rst) begin
      m_bvalid = 0; m_rvalid = 0; pend_b = 0; pend_r = 0;
    end else begin
      m_awready = ($urandom % 4) != 0;
      m_wready  = ($urandom % 4) != 0;
      m_arready = ($urandom % 4) != 0;
      if (pend_b) begin m_bvalid = 0; pend_b = 0; end
      if (pend_r) begin
        pend_r = 0;
        if (r_beat == r_len) m_rvalid = 0;
        else begin
          r_beat++;
          m_rdata = mem_word(r_addr, r_beat);
          m_rlast = (r_beat == r_len);
        end
      end
      #0.1;
      if (m_awvalid && m_awready) begin
        mem_aw_cnt++; mem_awaddr = m_awaddr; mem_awlen = m_awlen; b_id = m_awid;
      end
      if (m_wvalid && m_wready) begin
        mem_w_cnt++; mem_wsum = mem_wsum + m_wdata;
        if (m_wlast) begin m_bvalid = 1; m_bid = b_id; m_bresp = 2'b00; end
      end
      if (m_bvalid && m_bready) pend_b = 1;
      if (m_arvalid && m_arready) begin
        mem_ar_cnt++; r_addr = m_araddr; r_len = int'(m_arlen); r_beat = 0;
        m_rvalid = 1; m_rid = m_arid; m_rresp = 2'b00;
        m_rdata = mem_word(m_araddr, 0); m_rlast = (m_arlen == 0);
      end
      if (m_rvalid && m_rready) pend_r = 1;
    end
  end

  // R8: write and read responses must never be offered together.
  int overlap = 0;
  always @(negedge clk) if (!rst && s_bvalid && s_rvalid) overlap++;

  task automatic do_write(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                          input int len, input bit attr, input bit prot, input bit intl);
    bit ab, rt, got_b, got_f;
    int aw0, w0, guard;
    logic [DATA_W-1:0] sum0, dsum;
    ab = exp_abort(failed_state, attr, prot, intl);
    rt = ab & intl;
    aw0 = mem_aw_cnt; w0 = mem_w_cnt; sum0 = mem_wsum; dsum = 0;
    @(negedge clk);
    s_awvalid = 1; s_awid = id; s_awaddr = addr; s_awlen = LEN_W'(len);
    s_aw_attr_fault = attr; s_aw_prot_fault = prot; s_aw_internal = intl;
    guard = 0;
    forever begin #2; if (s_awready || guard > 500) break; guard++; @(negedge clk); end
    @(negedge clk);
    s_awvalid = 0;
    for (int b = 0; b <= len; b++) begin
      s_wvalid = ($urandom % 3) != 0;
      s_wdata = {$urandom, $urandom}; s_wlast = (b == len);
      guard = 0;
      forever begin
        #2;
        if (s_wvalid && s_wready) break;
        if (guard > 500) break;
        guard++;
        @(negedge clk);
        s_wvalid = 1;
      end
      dsum = dsum + s_wdata;
      @(negedge clk);
    end
    s_wvalid = 0; s_wlast = 0;
    got_b = 0; got_f = 0; guard = 0;
    forever begin
      s_bready = ($urandom % 3) != 0;
      #2;
      if (fault_valid) begin
        got_f = 1;
        chk(rt, "R6 unexpected write fault", 1, rt);
        chk(fault_id == id, "R6 fault id", fault_id, id);
        chk(fault_write == 1'b1, "R6 fault write flag", fault_write, 1);
        break;
      end
      if (s_bvalid && s_bready) begin
        got_b = 1;
        chk(s_bid == id, "R3 write response id", s_bid, id);
        chk(s_bresp == (ab ? 2'b10 : 2'b00), ab ? "R3 error bresp" : "R1 forwarded bresp", s_bresp, ab ? 2 : 0);
        break;
      end
      if (guard > 2000) break;
      guard++;
      @(negedge clk);
    end
    @(negedge clk); s_bready = 0;
    if (rt) begin
      chk(got_f && !got_b, "R6 internal write abort answered as fault only", got_b, 0);
      for (int k = 0; k < 3; k++) begin
        #2; chk(!s_bvalid, "R6 no write response after fault", s_bvalid, 0); @(negedge clk);
      end
    end else chk(got_b, "R3 write response received", got_b, 1);
    if (ab) begin
      chk(mem_aw_cnt == aw0 && mem_w_cnt == w0, "R2 aborted write reached memory",
          mem_w_cnt - w0, 0);
    end else begin
      chk(mem_aw_cnt == aw0 + 1 && mem_awaddr == addr && mem_awlen == LEN_W'(len),
          "R1 forwarded write address", mem_awaddr, addr);
      chk(mem_w_cnt == w0 + len + 1 && mem_wsum - sum0 == dsum, "R1 forwarded write data",
          mem_wsum - sum0, dsum);
    end
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                         input int len, input bit attr, input bit prot, input bit intl);
    bit ab, rt, got_f, last_ok, data_ok;
    int ar0, beats, guard;
    ab = exp_abort(failed_state, attr, prot, intl);
    rt = ab & intl;
    ar0 = mem_ar_cnt; beats = 0; got_f = 0; last_ok = 1; data_ok = 1;
    @(negedge clk);
    s_arvalid = 1; s_arid = id; s_araddr = addr; s_arlen = LEN_W'(len);
    s_ar_attr_fault = attr; s_ar_prot_fault = prot; s_ar_internal = intl;
    guard = 0;
    forever begin #2; if (s_arready || guard > 500) break; guard++; @(negedge clk); end
    @(negedge clk);
    s_arvalid = 0;
    guard = 0;
    forever begin
      s_rready = ($urandom % 3) != 0;
      #2;
      if (fault_valid) begin
        got_f = 1;
        chk(fault_id == id && fault_write == 1'b0, "R6 read fault id/flag", {fault_write, fault_id}, id);
        break;
      end
      if (s_rvalid && s_rready) begin
        if (s_rid != id) data_ok = 0;
        if (ab) begin
          if (s_rdata != {DATA_W{1'b1}} || s_rresp != 2'b10) data_ok = 0;
        end else begin
          if (s_rdata != mem_word(addr, beats) || s_rresp != 2'b00) data_ok = 0;
        end
        if (s_rlast != (beats == len)) last_ok = 0;
        beats++;
        if (s_rlast || beats > len + 4) break;
      end
      if (guard > 3000) break;
      guard++;
      @(negedge clk);
    end
    @(negedge clk); s_rready = 0;
    if (rt) begin
      chk(got_f && beats == 0, "R6 internal read abort answered as fault only", beats, 0);
      for (int k = 0; k < 3; k++) begin
        #2; chk(!s_rvalid, "R6 no read data after fault", s_rvalid, 0); @(negedge clk);
      end
    end else begin
      chk(beats == len + 1, ab ? "R4 error beat count" : "R1 forwarded beat count", beats, len + 1);
      chk(last_ok, "R4 last only on final beat", last_ok, 1);
      chk(data_ok, ab ? "R5 fill data and error code" : "R1 forwarded read data", data_ok, 1);
    end
    chk(mem_ar_cnt == ar0 + (ab ? 0 : 1), ab ? "R2 aborted read reached memory" : "R1 read forwarded",
        mem_ar_cnt - ar0, ab ? 0 : 1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    #2;
    // R9 reset state
    chk(!s_bvalid && !s_rvalid && !m_awvalid && !m_arvalid && !m_wvalid && !fault_valid,
        "R9 idle after reset", {s_bvalid, s_rvalid, m_awvalid, m_arvalid, fault_valid}, 0);

    // Directed corners
    do_write(4'h1, 32'h1000, 3, 0, 0, 0);  // R1
    do_read (4'h2, 32'h2000, 2, 0, 0, 0);  // R1
    do_read (4'h3, 32'h3000, 0, 1, 0, 0);  // R4 single-beat error
    do_read (4'h4, 32'h3100, 15, 0, 1, 0); // R4 long error burst, R5
    do_write(4'h5, 32'h4000, 0, 0, 1, 0);  // R3 single beat
    do_write(4'h6, 32'h4100, 12, 1, 0, 0); // R3 long burst
    do_write(4'h7, 32'h5000, 2, 1, 0, 1);  // R6 internal write
    do_read (4'h8, 32'h5100, 3, 0, 1, 1);  // R6 internal read
    failed_state = 1;                      // R7
    do_write(4'h9, 32'h6000, 1, 0, 0, 0);
    do_read (4'hA, 32'h6100, 2, 0, 0, 0);
    do_read (4'hB, 32'h6200, 1, 0, 0, 1);  // internal walk still forwarded
    do_write(4'hC, 32'h6300, 1, 0, 0, 1);
    do_read (4'hD, 32'h6400, 0, 1, 0, 1);  // internal with fault
    failed_state = 0;
    // R8: simultaneous requests on both channels with one ID
    fork
      do_write(4'hE, 32'h7000, 4, 0, 0, 0);
      do_read (4'hE, 32'h7100, 4, 0, 0, 0);
    join
    fork
      do_write(4'hE, 32'h7200, 2, 1, 0, 0);
      do_read (4'hE, 32'h7300, 3, 0, 1, 0);
    join

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      bit at, pr, it, wr;
      int ln;
      at = ($urandom % 6) == 0;
      pr = ($urandom % 6) == 0;
      it = ($urandom % 4) == 0;
      wr = $urandom % 2;
      ln = $urandom % 8;
      if (($urandom % 10) == 0) failed_state = ~failed_state;
      if (wr) do_write(ID_W'($urandom), {$urandom} & 32'hFFFF_FFF8, ln, at, pr, it);
      else    do_read (ID_W'($urandom), {$urandom} & 32'hFFFF_FFF8, ln, at, pr, it);
    end
    chk(overlap == 0, "R8 write and read responses overlapped", overlap, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule